// File: doc/BRIEF.md
# Stream-to-Memory DMA Write Channel

This block is one memory-write DMA channel that software programs through a small register file. Software sets the run bit and the interrupt enables, then loads a 64-bit destination address through a low and a high register. Writing a non-zero byte length then arms the channel. Once armed, the channel accepts one packet on an AXI4-Stream slave port and writes each beat to memory through a simple word write port, at successive byte addresses starting at the destination.

The packet ends at TLAST, not when the byte count runs out. The programmed length is therefore a buffer capacity, and it must cover the whole packet. When the packet completes, the length register holds the number of bytes actually received, a done flag is set, and an interrupt is raised if it is enabled. If a beat would overrun the capacity before TLAST arrives, the channel drops that beat, sets an error flag and halts. It stays halted until software clears the run bit.

Top module: `s2m_dma_chan`

## Requirements
- R1: After reset, `s_tready`, `mem_we` and `irq` are low and every register reads zero.
- R2: A write of a non-zero value to LEN (index 4) arms the channel when run (CTRL index 0, bit 0) is set and the channel is neither armed nor halted. `s_tready` rises in the cycle after the write, and STAT (index 1) bit 0 reads 1. A zero value, or run clear, leaves the channel idle.
- R3: Each accepted beat that fits the capacity raises `mem_we` in the same cycle. The write carries `mem_addr` = {DST_HI (index 3), DST_LO (index 2)} plus the bytes accepted so far, with `mem_wdata` = `s_tdata` and `mem_be` = `s_tkeep`. A beat's byte count is the number of set `s_tkeep` bits.
- R4: The cycle after a beat with `s_tlast` is accepted, `s_tready` is low and STAT bit 1 (done) is set. From then on LEN reads the total bytes received.
- R5: `irq` is high exactly when done is set with CTRL bit 1 set, or error is set with CTRL bit 2 set.
- R6: A beat that would take the byte total past LEN is not written. The channel then sets STAT bit 2 (error) and bit 3 (halted), drops `s_tready`, and LEN reads the bytes written before that beat. While halted, a LEN write does not arm. Writing CTRL bit 0 = 0 clears halted.
- R7: Writing 1 to STAT bit 1 or bit 2 clears that flag. Writing 0 to a bit leaves it unchanged.
- R8: A packet whose byte total equals LEN exactly completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| s_tvalid | input | 1 | Stream beat valid |
| s_tready | output | 1 | Stream beat ready |
| s_tdata | input | DATA_W | Stream beat data |
| s_tkeep | input | DATA_W/8 | Stream byte enables, low bytes contiguous |
| s_tlast | input | 1 | Last beat of packet |
| mem_we | output | 1 | Memory word write strobe |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte enables |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives packets whose byte totals land below, exactly on, and past the programmed capacity, with partial final beats. An off-by-one in the capacity compare would either flag an error on an exact fit or write one beat too many. It checks that the overflowing beat never reaches memory, that a halted channel refuses re-arming until run is cleared, and that LEN reports the bytes received rather than the capacity. A design that took zero or a cleared run bit as an arm, or that cleared flags on written zeros, would show the stream ready or lose a pending interrupt.

// File: rtl/s2m_dma_chan.sv
module s2m_dma_chan #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24,
  parameter int RA_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [RA_W-1:0]       reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic                  s_tvalid,
  output logic                  s_tready,
  input  logic [DATA_W-1:0]     s_tdata,
  input  logic [DATA_W/8-1:0]   s_tkeep,
  input  logic                  s_tlast,
  output logic                  mem_we,
  output logic [63:0]           mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic                  irq
);
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(0);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(1);
  localparam logic [RA_W-1:0] A_DLO  = RA_W'(2);
  localparam logic [RA_W-1:0] A_DHI  = RA_W'(3);
  localparam logic [RA_W-1:0] A_LEN  = RA_W'(4);

  logic             run, ie_done, ie_err;
  logic             armed, done, err, halted;
  logic [63:0]      dst;
  logic [CNT_W-1:0] cap, cnt;
  logic [CNT_W:0]   sum;
  logic             beat, ovf, arm;

  assign s_tready  = armed;
  assign beat      = s_tvalid & armed;
  assign sum       = {1'b0, cnt} + (CNT_W+1)'($countones(s_tkeep));
  assign ovf       = sum > {1'b0, cap};
  assign mem_we    = beat & ~ovf;
  assign mem_addr  = dst + 64'(cnt);
  assign mem_wdata = s_tdata;
  assign mem_be    = s_tkeep;
  assign irq       = (done & ie_done) | (err & ie_err);
  assign arm       = reg_wr && reg_addr == A_LEN && |reg_wdata[CNT_W-1:0]
                     && run && !halted && !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0; ie_done <= 1'b0; ie_err <= 1'b0;
      armed <= 1'b0; done <= 1'b0; err <= 1'b0; halted <= 1'b0;
      dst <= '0; cap <= '0; cnt <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTRL: begin
            run     <= reg_wdata[0];
            ie_done <= reg_wdata[1];
            ie_err  <= reg_wdata[2];
            if (!reg_wdata[0]) begin
              halted <= 1'b0;
              armed  <= 1'b0;
            end
          end
          A_STAT: begin
            if (reg_wdata[1]) done <= 1'b0;
            if (reg_wdata[2]) err  <= 1'b0;
          end
          A_DLO: if (!armed) dst[31:0]  <= reg_wdata;
          A_DHI: if (!armed) dst[63:32] <= reg_wdata;
          A_LEN: if (!armed) cap <= reg_wdata[CNT_W-1:0];
          default: ;
        endcase
      end
      if (arm) begin
        armed <= 1'b1;
        cnt   <= '0;
      end
      if (beat) begin
        if (ovf) begin
          err    <= 1'b1;
          halted <= 1'b1;
          armed  <= 1'b0;
          cap    <= cnt;
        end else begin
          cnt <= sum[CNT_W-1:0];
          if (s_tlast) begin
            done  <= 1'b1;
            armed <= 1'b0;
            cap   <= sum[CNT_W-1:0];
          end
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {29'b0, ie_err, ie_done, run};
      A_STAT:  reg_rdata = {28'b0, halted, err, done, armed};
      A_DLO:   reg_rdata = dst[31:0];
      A_DHI:   reg_rdata = dst[63:32];
      A_LEN:   reg_rdata = 32'(cap);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/s2m_dma_chan_chk.sv
module s2m_dma_chan_chk (
  input logic clk,
  input logic rst,
  input logic reg_wr,
  input logic s_tvalid,
  input logic s_tready,
  input logic s_tlast,
  input logic mem_we,
  input logic irq
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) rst |=> !s_tready && !irq);
  // R2
  arm_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(s_tready) |-> $past(reg_wr));
  // R3
  write_needs_beat_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> s_tvalid && s_tready);
  // R4
  last_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready && s_tlast && mem_we) |=> !s_tready);
  // R6
  stop_after_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (s_tvalid && s_tready && !mem_we) |=> !s_tready);
endmodule

bind s2m_dma_chan s2m_dma_chan_chk chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .s_tvalid(s_tvalid),
  .s_tready(s_tready), .s_tlast(s_tlast), .mem_we(mem_we), .irq(irq)
);

// File: tb/tb_s2m_dma_chan.sv
module tb_s2m_dma_chan;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        s_tvalid = 1'b0, s_tready, s_tlast = 1'b0;
  logic [31:0] s_tdata = '0;
  logic [3:0]  s_tkeep = '0;
  logic        mem_we, irq;
  logic [63:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_be;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  s2m_dma_chan dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .s_tvalid(s_tvalid),
    .s_tready(s_tready), .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .irq(irq)
  );

  // {capacity, beats, last keep, expected LEN, expected error}
  localparam logic [44:0] VEC [5] = '{
    {16'd16,  8'd4, 4'hF, 16'd16, 1'b0},
    {16'd100, 8'd3, 4'h3, 16'd10, 1'b0},
    {16'd7,   8'd2, 4'h7, 16'd7,  1'b0},
    {16'd9,   8'd4, 4'hF, 16'd8,  1'b1},
    {16'd1,   8'd1, 4'h1, 16'd1,  1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic send(input int cap, input int beats, input logic [3:0] klast,
                      input logic [63:0] base);
    int cnt = 0;
    for (int j = 0; j < beats; j++) begin
      logic [3:0] k;
      int nb;
      bit ov;
      k  = (j == beats - 1) ? klast : 4'hF;
      nb = $countones(k);
      ov = (cnt + nb) > cap;
      @(negedge clk);
      s_tvalid = 1'b1; s_tdata = 32'hA500_0000 + j; s_tkeep = k;
      s_tlast = (j == beats - 1);
      #2;
      chk("R2 ready while armed", s_tready, 1);
      chk(ov ? "R6 overflow beat not written" : "R3 beat written", mem_we, !ov);
      if (!ov) begin
        chk("R3 address", mem_addr, base + cnt);
        chk("R3 data", mem_wdata, 32'hA500_0000 + j);
        chk("R3 byte enables", mem_be, k);
      end
      @(posedge clk);
      if (ov) break;
      cnt += nb;
    end
    @(negedge clk);
    s_tvalid = 1'b0; s_tlast = 1'b0;
    #1 chk("R4/R6 ready low after packet", s_tready, 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 ready", s_tready, 0);
    chk("R1 irq", irq, 0);
    chk("R1 mem_we", mem_we, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 register zero", d, 0);
    end
    // R2: run clear, then zero length
    wr(3'd4, 32'd8);
    #1 chk("R2 run clear no arm", s_tready, 0);
    rd(3'd1, d); chk("R2 stat idle", d, 0);
    wr(3'd0, 32'd1);
    wr(3'd4, 32'd0);
    #1 chk("R2 zero length no arm", s_tready, 0);

    for (int i = 0; i < 5; i++) begin
      int cap, beats, elen;
      logic [3:0] kl;
      bit eerr;
      logic [63:0] base;
      {cap, beats, kl, elen, eerr} = {16'(VEC[i][44:29]), 8'(VEC[i][28:21]),
                                      VEC[i][20:17], 16'(VEC[i][16:1]), VEC[i][0]};
      cap = int'(VEC[i][44:29]); beats = int'(VEC[i][28:21]);
      kl = VEC[i][20:17]; elen = int'(VEC[i][16:1]); eerr = VEC[i][0];
      base = {32'(i), 32'h1000 * (i + 1)};
      wr(3'd0, 32'd7);
      wr(3'd2, base[31:0]);
      wr(3'd3, base[63:32]);
      wr(3'd4, 32'(cap));
      rd(3'd1, d); chk("R2 stat busy", d, 1);
      send(cap, beats, kl, base);
      rd(3'd1, d);
      chk(eerr ? "R6 error and halted" : "R4/R8 done flag", d, eerr ? 32'hC : 32'h2);
      chk("R5 irq enabled", irq, 1);
      rd(3'd4, d); chk("R4/R6 LEN received bytes", d, 32'(elen));
      if (eerr) begin
        wr(3'd4, 32'd5);
        #1 chk("R6 halted ignores arm", s_tready, 0);
        wr(3'd0, 32'd0);
        rd(3'd1, d); chk("R6 run clear releases halt", d, 32'h4);
      end
      wr(3'd1, 32'h6);
      rd(3'd1, d); chk("R7 flags cleared", d, 0);
      #1 chk("R7 irq cleared", irq, 0);
    end

    // R5: enables gate irq
    wr(3'd0, 32'd1);
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    wr(3'd4, 32'd4);
    send(4, 1, 4'hF, 64'h0);
    #1 chk("R5 done without enable", irq, 0);
    wr(3'd0, 32'd3);
    #1 chk("R5 done enabled", irq, 1);
    wr(3'd0, 32'd5);
    #1 chk("R5 error enable only", irq, 0);
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R7 zero write keeps done", d, 32'h2);
    wr(3'd1, 32'h2);
    rd(3'd1, d); chk("R7 done cleared", d, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule